// File: doc/BRIEF.md
# Buffered clocked serial transmitter

This block sends bytes out one bit at a time on a serial data line, least-significant bit first, alongside a serial clock. A single holding buffer sits in front of the shift register, so software can write the next byte while the current one is still going out. Each time the buffer contents move into the shifter, the block raises a one-cycle "buffer empty" pulse to ask for more data. The serial clock comes from one of two sources. It is either divided down from the system clock, or it is an external clock input that is sampled through a synchronizer.

Software controls the block with a buffer write strobe and a control write strobe. The control write carries a run bit, an inhibit bit, a two-bit operating-mode field and a clock-source select. It writes a byte, then starts the transfer by setting run. When it has no more data, it either clears run, which lets the byte in flight finish, or sets inhibit, which stops everything at once. With the internal clock, the clock stalls high whenever a byte ends and the buffer is empty, and it resumes as soon as the buffer is written. With the external clock, the block never stalls: an empty buffer at a byte boundary re-sends whatever the buffer last held.

The control FSM has four states. IDLE waits for a start. LEAD has started but the first falling clock edge has not yet come. SHIFT is moving bits out. WAIT is stalled with the internal clock stopped. The transitions are:
- start: IDLE to LEAD, which also loads the shifter.
- first fall: LEAD to SHIFT.
- reload: SHIFT stays in SHIFT at the byte boundary and loads the shifter again.
- stall: SHIFT to WAIT.
- resume: WAIT to LEAD, which also loads the shifter.
- finish: SHIFT or WAIT to IDLE when run is clear.
- abort: any state to IDLE.

Top module: `sertx_engine`

## Requirements
- R1: Bytes leave on `sdo` least-significant bit first. `sdo` only changes on a falling edge of the serial clock and is meant to be sampled on the rising edge. With the internal clock, `sclk_out` idles high and, while running, has a period of exactly `DIV` system clocks (`DIV` even, at least 2).
- R2: Every move of the buffer into the shifter empties the buffer and produces exactly one single-cycle pulse on `buf_empty_irq`.
- R3: A start needs all of the following: `ctl_wr` with `ctl_run`=1 and `ctl_halt`=0, the block idle, and the buffer holding an unsent byte. A start request made while the buffer is empty is ignored, and `busy` stays 0.
- R4: The mode field encodes 2'b01 as transmit. The other codes (00, 10, 11) never start a transfer and do not consume the buffer.
- R5: From the cycle `busy` rises until the first falling edge of the serial clock, `sdo` keeps the last bit of the previous transfer. The same holds after a stall resumes.
- R6: When the buffer is full at a byte boundary, the next byte follows with no gap in the serial clock.
- R7: With the internal clock and an empty buffer at a byte boundary, `sclk_out` stays high, `busy` stays 1 and `sdo` holds bit 7 of the last byte. A buffer write resumes the transfer.
- R8: With the external clock (`ctl_extclk`=1 at start), bits advance on synchronized falling edges of `sclk_in` and `sclk_out` stays high. An empty buffer at a boundary re-sends the buffer's previous contents and still pulses `buf_empty_irq`.
- R9: Writing `ctl_run`=0 ends the transfer gracefully. The byte in the shifter completes, `busy` clears at the byte boundary, and a byte waiting in the buffer is kept for the next start. In the stalled state, `busy` clears immediately.
- R10: Writing `ctl_halt`=1 aborts the transfer. `busy` is 0 and `sclk_out` is high from the next cycle, and no further clock edges occur.
- R11: After reset, `busy`=0, `sdo`=0, `sclk_out`=1 and `buf_empty_irq`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| buf_wr | input | 1 | Write strobe for the holding buffer |
| buf_wdata | input | W | Byte to place in the buffer |
| ctl_wr | input | 1 | Control write strobe |
| ctl_run | input | 1 | Run bit: 1 starts, 0 requests a graceful stop |
| ctl_halt | input | 1 | Inhibit bit: 1 aborts immediately |
| ctl_mode | input | 2 | Operating mode, 2'b01 = transmit |
| ctl_extclk | input | 1 | Clock source: 1 = external `sclk_in`, 0 = internal divider |
| sclk_in | input | 1 | External serial clock, idles high |
| sclk_out | output | 1 | Internally generated serial clock, idles high |
| sdo | output | 1 | Serial data out |
| busy | output | 1 | Transfer in progress |
| buf_empty_irq | output | 1 | One-cycle pulse on each buffer-to-shifter move |

## Verification
The bench streams all 256 byte values back to back with the internal clock. A design that shifted in the wrong order, dropped or repeated a bit at the boundary, or let the clock period drift would show up as miscompared bytes or an off-period interval. It deliberately lets the buffer run dry, to catch a clock that keeps toggling in the stall, or a line that jumps before the first falling edge of a resumed or fresh transfer. Graceful stop is checked by restarting without a new write: a design that drained the waiting byte, or that dropped the byte already in flight, sends the wrong thing. The external-clock run forces an underrun, to catch a design that stalls, or that sends something other than the previous buffer contents, where it should re-send them.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_WAIT
    } tx_state_e;

    localparam logic [1:0] MODE_TX = 2'b01;

endpackage

// File: rtl/sertx_sclk_gen.sv
module sertx_sclk_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic int_run,
    input  logic ext_sel,
    input  logic hold,
    input  logic sclk_in,
    output logic fall_due,
    output logic sclk_out
);
    localparam int HALF = DIV / 2;

    logic       sclk_q;
    logic       at_term;
    logic [2:0] ext_pipe;
    logic       fall_ext;

    // half-period timer: a variant without a counter when the divider is 2
    generate
        if (HALF <= 1) begin : g_nodiv
            assign at_term = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(HALF);
            logic [CW-1:0] cnt;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt <= '0;
                end else if (!int_run || cnt == CW'(HALF - 1)) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
            assign at_term = (cnt == CW'(HALF - 1));
        end
    endgenerate

    // internal clock: high while idle, held high when the controller asks
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b1;
        end else if (!int_run) begin
            sclk_q <= 1'b1;
        end else if (at_term) begin
            sclk_q <= sclk_q ? hold : 1'b1;
        end
    end

    // external clock: two-stage synchronizer plus previous value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_pipe <= 3'b111;
        end else begin
            ext_pipe <= {ext_pipe[1:0], sclk_in};
        end
    end

    assign fall_ext = ext_pipe[2] & ~ext_pipe[1];
    assign fall_due = ext_sel ? fall_ext : (int_run & at_term & sclk_q);
    assign sclk_out = sclk_q | ~int_run;

endmodule

// File: rtl/sertx_holdbuf.sv
module sertx_holdbuf #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         take,
    output logic [W-1:0] data_q,
    output logic         full_q,
    output logic         irq_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            full_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            if (wr) begin
                data_q <= wdata;
            end
            if (wr) begin
                full_q <= 1'b1;
            end else if (take) begin
                full_q <= 1'b0;
            end
            irq_q <= take;
        end
    end
endmodule

// File: rtl/sertx_fsm.sv
module sertx_fsm
    import sertx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         abort,
    input  logic         run,
    input  logic         ext,
    input  logic         fall_due,
    input  logic         buf_full,
    input  logic [W-1:0] buf_data,
    output logic         take,
    output logic         hold,
    output logic         int_run,
    output logic         busy,
    output logic         sdo,
    output tx_state_e    state_o
);
    localparam int CNT_W = $clog2(W);

    tx_state_e        state, nxt;
    logic [W-1:0]     shreg;
    logic [CNT_W-1:0] bitcnt;
    logic             last_bit;
    logic             first_fall, advance, reload;

    assign last_bit = (bitcnt == CNT_W'(W - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // next state and transition strobes
    always_comb begin
        nxt  = state;
        take = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    nxt  = ST_LEAD;
                    take = 1'b1;
                end
            end
            ST_LEAD: begin
                if (fall_due) begin
                    nxt = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (fall_due && last_bit) begin
                    if (!run) begin
                        nxt = ST_IDLE;
                    end else if (buf_full || ext) begin
                        take = 1'b1;
                    end else begin
                        nxt = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (!run) begin
                    nxt = ST_IDLE;
                end else if (buf_full) begin
                    nxt  = ST_LEAD;
                    take = 1'b1;
                end
            end
            default: nxt = ST_IDLE;
        endcase
        if (abort) begin
            nxt  = ST_IDLE;
            take = 1'b0;
        end
    end

    // outputs derived from the current state
    always_comb begin
        busy    = (state != ST_IDLE);
        int_run = ((state == ST_LEAD) || (state == ST_SHIFT)) && !ext;
        hold    = (state == ST_SHIFT) && last_bit && (!run || (!buf_full && !ext));
        state_o = state;
    end

    assign first_fall = (state == ST_LEAD) && fall_due && !abort;
    assign advance    = (state == ST_SHIFT) && fall_due && !last_bit && !abort;
    assign reload     = (state == ST_SHIFT) && fall_due && last_bit && take;

    // shift path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg  <= '0;
            bitcnt <= '0;
            sdo    <= 1'b0;
        end else begin
            if (take) begin
                shreg <= buf_data;
            end else if (advance) begin
                shreg <= shreg >> 1;
            end
            if (first_fall) begin
                sdo    <= shreg[0];
                bitcnt <= '0;
            end else if (advance) begin
                sdo    <= shreg[1];
                bitcnt <= bitcnt + 1'b1;
            end else if (reload) begin
                sdo    <= buf_data[0];
                bitcnt <= '0;
            end
        end
    end

endmodule

// File: rtl/sertx_engine.sv
module sertx_engine
    import sertx_pkg::*;
#(
    parameter int DIV = 4,
    parameter int W   = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         buf_wr,
    input  logic [W-1:0] buf_wdata,
    input  logic         ctl_wr,
    input  logic         ctl_run,
    input  logic         ctl_halt,
    input  logic [1:0]   ctl_mode,
    input  logic         ctl_extclk,
    input  logic         sclk_in,
    output logic         sclk_out,
    output logic         sdo,
    output logic         busy,
    output logic         buf_empty_irq
);
    logic         run_q, ext_q;
    logic         start, abort;
    logic         take, hold, int_run, fall_due;
    logic         buf_full;
    logic [W-1:0] buf_data;
    tx_state_e    state;

    assign start = ctl_wr && ctl_run && !ctl_halt && (ctl_mode == MODE_TX)
                   && !busy && buf_full;
    assign abort = ctl_wr && ctl_halt;

    // control bits: clock source is latched only while idle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            ext_q <= 1'b0;
        end else if (ctl_wr) begin
            run_q <= ctl_run && !ctl_halt;
            if (!busy) begin
                ext_q <= ctl_extclk;
            end
        end
    end

    sertx_holdbuf #(.W(W)) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (buf_wr),
        .wdata  (buf_wdata),
        .take   (take),
        .data_q (buf_data),
        .full_q (buf_full),
        .irq_q  (buf_empty_irq)
    );

    sertx_sclk_gen #(.DIV(DIV)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .int_run  (int_run),
        .ext_sel  (ext_q),
        .hold     (hold),
        .sclk_in  (sclk_in),
        .fall_due (fall_due),
        .sclk_out (sclk_out)
    );

    sertx_fsm #(.W(W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .abort    (abort),
        .run      (run_q),
        .ext      (ext_q),
        .fall_due (fall_due),
        .buf_full (buf_full),
        .buf_data (buf_data),
        .take     (take),
        .hold     (hold),
        .int_run  (int_run),
        .busy     (busy),
        .sdo      (sdo),
        .state_o  (state)
    );

endmodule

// File: rtl/sertx_engine_chk.sv
module sertx_engine_chk
    import sertx_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_wr,
    input logic       ctl_run,
    input logic       ctl_halt,
    input logic [1:0] ctl_mode,
    input logic       sclk_out,
    input logic       sdo,
    input logic       busy,
    input logic       buf_empty_irq,
    input logic       buf_full,
    input logic       ext_q,
    input tx_state_e  state
);
    assert_sdo_on_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sdo) && !$past(ext_q)) |-> $fell(sclk_out));

    assert_irq_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        buf_empty_irq |=> !buf_empty_irq);

    assert_empty_start_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_run && !busy && !buf_full) |=> !busy);

    assert_mode_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_mode != 2'b01 && !busy) |=> !busy);

    assert_stall_clock_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> (sclk_out && busy));

    assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_halt) |=> (!busy && sclk_out));

    assert_idle_clock_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sclk_out);

endmodule

bind sertx_engine sertx_engine_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctl_wr        (ctl_wr),
    .ctl_run       (ctl_run),
    .ctl_halt      (ctl_halt),
    .ctl_mode      (ctl_mode),
    .sclk_out      (sclk_out),
    .sdo           (sdo),
    .busy          (busy),
    .buf_empty_irq (buf_empty_irq),
    .buf_full      (buf_full),
    .ext_q         (ext_q),
    .state         (state)
);

// File: tb/sertx_engine_test.sv
`timescale 1ns/1ps
module sertx_engine_test;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       buf_wr = 1'b0;
    logic [7:0] buf_wdata = '0;
    logic       ctl_wr = 1'b0, ctl_run = 1'b0, ctl_halt = 1'b0, ctl_extclk = 1'b0;
    logic [1:0] ctl_mode = 2'b00;
    logic       sclk_in = 1'b1;
    logic       sclk_out, sdo, busy, buf_empty_irq;

    int nvec = 0, nerr = 0;
    int irq_cnt = 0, fall_cnt = 0, ncap = 0, bitpos = 0, cyc = 0, last_fall = 0, per_bad = 0;
    bit per_en = 1'b0;
    logic prev_sclk = 1'b1;
    logic [7:0] shbuf = '0;
    logic [7:0] cap [0:1023];

    always #2.5 clk = ~clk;

    sertx_engine #(.DIV(DIV), .W(8)) uut (
        .clk(clk), .rst_n(rst_n), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
        .ctl_wr(ctl_wr), .ctl_run(ctl_run), .ctl_halt(ctl_halt), .ctl_mode(ctl_mode),
        .ctl_extclk(ctl_extclk), .sclk_in(sclk_in), .sclk_out(sclk_out), .sdo(sdo),
        .busy(busy), .buf_empty_irq(buf_empty_irq)
    );

    // port monitor: counts pulses and edges, captures bits on rising sclk_out
    always @(negedge clk) begin
        if (rst_n) begin
            if (buf_empty_irq) irq_cnt++;
            if (prev_sclk && !sclk_out) begin
                fall_cnt++;
                if (per_en && (cyc - last_fall) != DIV) per_bad++;
                last_fall = cyc;
            end
            if (!prev_sclk && sclk_out) begin
                shbuf = {sdo, shbuf[7:1]};
                bitpos++;
                if (bitpos == 8) begin
                    if (ncap < 1024) cap[ncap] = shbuf;
                    ncap++;
                    bitpos = 0;
                end
            end
            if (!busy) bitpos = 0;
        end
        prev_sclk = sclk_out;
        cyc++;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_buf(input logic [7:0] d);
        @(negedge clk); buf_wr = 1'b1; buf_wdata = d;
        @(negedge clk); buf_wr = 1'b0;
    endtask

    task automatic wr_ctl(input logic run, input logic halt, input logic [1:0] mode, input logic ext);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_run = run; ctl_halt = halt; ctl_mode = mode; ctl_extclk = ext;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic ext_bit(output logic b);
        @(negedge clk); sclk_in = 1'b0;
        repeat (6) @(negedge clk);
        b = sdo; sclk_in = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    function automatic logic [7:0] pat(input int k);
        int t;
        t = k * 29 + 165;
        return t[7:0];
    endfunction

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nvec++; nerr++;
        $display("FAIL watchdog expired actual=%0h expected=%0h", cyc, 0);
        summary();
        $finish;
    end

    initial begin
        int irq0, cap0, f0, bad;
        logic [7:0] eb;
        logic       b;
        logic       sdo_prev;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(busy == 1'b0, "R11 busy", busy, 0);
        chk(sclk_out == 1'b1, "R11 sclk_out", sclk_out, 1);
        chk(sdo == 1'b0, "R11 sdo", sdo, 0);
        chk(buf_empty_irq == 1'b0, "R11 irq", buf_empty_irq, 0);

        // R3: start with empty buffer is ignored
        wr_ctl(1'b1, 1'b0, 2'b01, 1'b0);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R3 empty start", busy, 0);

        // R4: non-transmit mode codes never start nor consume the buffer
        wr_buf(8'hA5);
        irq0 = irq_cnt;
        for (int m = 0; m < 4; m++) begin
            if (m != 1) begin
                wr_ctl(1'b1, 1'b0, 2'(m), 1'b0);
                repeat (3) @(negedge clk);
                chk(busy == 1'b0 && irq_cnt == irq0, "R4 mode gate", {busy, 2'(m)}, 0);
            end
        end

        // R5 lead phase, then R1/R6 stream of all 256 values (pat(0) = A5)
        sdo_prev = sdo;
        irq0 = irq_cnt;
        cap0 = ncap;
        wr_ctl(1'b1, 1'b0, 2'b01, 1'b0);
        chk(busy == 1'b1, "R3 start", busy, 1);
        bad = 0;
        while (busy && sclk_out) begin
            if (sdo != sdo_prev) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R5 lead holds last bit", bad, 0);
        chk(irq_cnt == irq0 + 1, "R2 irq at start", irq_cnt - irq0, 1);
        @(negedge clk);
        per_en = 1'b1;
        for (int k = 1; k < 256; k++) begin
            while (irq_cnt < irq0 + k) @(negedge clk);
            wr_buf(pat(k));
        end
        while (ncap < cap0 + 256) @(negedge clk);
        per_en = 1'b0;
        for (int k = 0; k < 256; k++) begin
            chk(cap[cap0 + k] == pat(k), "R1 R6 stream byte", cap[cap0 + k], pat(k));
        end
        chk(per_bad == 0, "R1 sclk period", per_bad, 0);
        chk(irq_cnt == irq0 + 256, "R2 irq count", irq_cnt - irq0, 256);

        // R7 stall: last byte 88h, bit 7 = 1
        f0 = fall_cnt;
        repeat (5 * DIV) @(negedge clk);
        chk(fall_cnt == f0 && sclk_out == 1'b1, "R7 clock stalled", fall_cnt - f0, 0);
        chk(busy == 1'b1, "R7 busy in stall", busy, 1);
        chk(sdo == 1'b1, "R7 line holds bit7", sdo, 1);
        cap0 = ncap;
        wr_buf(8'h3C);
        bad = 0;
        while (busy && sclk_out) begin
            if (sdo != 1'b1) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R5 lead after resume", bad, 0);
        while (ncap < cap0 + 1) @(negedge clk);
        chk(cap[cap0] == 8'h3C, "R7 resumed byte", cap[cap0], 8'h3C);

        // R9 stop while stalled
        repeat (3 * DIV) @(negedge clk);
        wr_ctl(1'b0, 1'b0, 2'b01, 1'b0);
        repeat (2) @(negedge clk);
        chk(busy == 1'b0, "R9 stop in stall", busy, 0);

        // R9 graceful stop mid-byte keeps the waiting byte
        wr_buf(8'h96);
        irq0 = irq_cnt;
        cap0 = ncap;
        wr_ctl(1'b1, 1'b0, 2'b01, 1'b0);
        while (irq_cnt < irq0 + 1) @(negedge clk);
        wr_buf(8'h4B);
        while (sclk_out) @(negedge clk);
        while (!sclk_out) @(negedge clk);
        wr_ctl(1'b0, 1'b0, 2'b01, 1'b0);
        while (busy) @(negedge clk);
        chk(ncap == cap0 + 1 && cap[cap0] == 8'h96, "R9 byte drained", cap[cap0], 8'h96);
        chk(irq_cnt == irq0 + 1, "R9 buffer not consumed", irq_cnt - irq0, 1);
        wr_ctl(1'b1, 1'b0, 2'b01, 1'b0);
        while (ncap < cap0 + 2) @(negedge clk);
        chk(cap[cap0 + 1] == 8'h4B, "R9 kept byte sent", cap[cap0 + 1], 8'h4B);
        repeat (3 * DIV) @(negedge clk);
        wr_ctl(1'b0, 1'b0, 2'b01, 1'b0);
        repeat (2) @(negedge clk);

        // R10 abort mid-byte
        wr_buf(8'hFF);
        cap0 = ncap;
        wr_ctl(1'b1, 1'b0, 2'b01, 1'b0);
        for (int r = 0; r < 3; r++) begin
            while (sclk_out) @(negedge clk);
            while (!sclk_out) @(negedge clk);
        end
        wr_ctl(1'b1, 1'b1, 2'b01, 1'b0);
        chk(busy == 1'b0, "R10 abort busy", busy, 0);
        chk(sclk_out == 1'b1, "R10 abort sclk", sclk_out, 1);
        f0 = fall_cnt;
        repeat (4 * DIV) @(negedge clk);
        chk(fall_cnt == f0 && ncap == cap0, "R10 no further edges", fall_cnt - f0, 0);

        // R8 external clock: underrun resends previous buffer contents
        f0 = fall_cnt;
        wr_buf(8'hC3);
        irq0 = irq_cnt;
        wr_ctl(1'b1, 1'b0, 2'b01, 1'b1);
        chk(busy == 1'b1, "R8 ext start", busy, 1);
        for (int i = 0; i < 8; i++) begin ext_bit(b); eb[i] = b; end
        chk(eb == 8'hC3, "R8 ext byte", eb, 8'hC3);
        for (int i = 0; i < 8; i++) begin
            ext_bit(b); eb[i] = b;
            if (i == 2) wr_buf(8'h5E);
        end
        chk(eb == 8'hC3, "R8 stale resend", eb, 8'hC3);
        chk(irq_cnt == irq0 + 2, "R8 irq on stale load", irq_cnt - irq0, 2);
        for (int i = 0; i < 8; i++) begin
            ext_bit(b); eb[i] = b;
            if (i == 4) wr_ctl(1'b0, 1'b0, 2'b01, 1'b1);
        end
        chk(eb == 8'h5E, "R8 reloaded byte", eb, 8'h5E);
        @(negedge clk); sclk_in = 1'b0;
        repeat (6) @(negedge clk);
        chk(busy == 1'b0, "R9 ext graceful end", busy, 0);
        sclk_in = 1'b1;
        repeat (4) @(negedge clk);
        chk(fall_cnt == f0, "R8 sclk_out quiet", fall_cnt - f0, 0);

        summary();
        $finish;
    end
endmodule